// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address and control front end of a synchronous burst memory of 32,768 words of 32 bits. On every rising clock edge it looks at two active-low address strobes, one meant for a processor and one for a memory controller. When a strobe is accepted, the block captures a 15-bit word address and the state of three chip enables. From then on the block walks a four-beat burst by stepping its two low address bits each time the active-low advance input is sampled low.

The processor strobe is only honoured when the three chip enables all select the device. The controller strobe always loads, and the enable state it captures becomes the registered selected flag. A static order input picks one of two burst orders. In interleaved order the start bits are XORed with the beat count. In linear order the beat count is added to the start bits and the sum wraps within the group of four. The upper thirteen address bits never change during a burst.

The outputs are the current array address and the registered selected flag. The memory array and the data path sit outside this block.

Top module: `bas_sequencer`

## Requirements
- R1: After reset, `array_addr` is 0 and `sel_q` is 0.
- R2: A sampled-low `adsp_n` while the device is enabled (`ce_n`=0, `ce2`=1, `ce2_n`=0) loads `addr_in`, clears the beat count and sets `sel_q` to 1. This holds whatever `adsc_n` and `adv_n` are in that cycle. After the load, `array_addr` equals the captured address.
- R3: A sampled-low `adsp_n` while any one of the three enables is false starts no access. If `adsc_n` is high, the cycle is handled as a non-strobe cycle.
- R4: A sampled-low `adsc_n` that the processor strobe has not preempted always loads `addr_in` and clears the beat count. `sel_q` becomes 1 only when `ce_n`=0, `ce2`=1 and `ce2_n`=0, and 0 otherwise.
- R5: A strobe cycle takes precedence over `adv_n`. After a load the beat count is 0, even when `adv_n` was low in the same cycle.
- R6: With `burst_mode`=1 (interleaved), the low two bits of `array_addr` are start XOR k at beat k.
- R7: With `burst_mode`=0 (linear), the low two bits of `array_addr` are (start + k) mod 4 at beat k.
- R8: Bits 14..2 of `array_addr` change only on a load. After four advances the burst wraps back to its start address.
- R9: A cycle with both strobes high and `adv_n` high leaves `array_addr` and `sel_q` unchanged.
- R10: While `sel_q` is 0, a non-strobe cycle with `adv_n` low does not advance the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | 15 | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Expansion enable, active high |
| ce2_n | input | 1 | Expansion enable, active low |
| burst_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| array_addr | output | 15 | Current array word address |
| sel_q | output | 1 | Registered device-selected flag |

## Verification
The hardest case to reach is the processor strobe that arrives while the device is deselected. The rejected strobe must fall through to the controller strobe or to the advance logic, and the result differs depending on which one follows. The stimulus reaches this case in two steps. First it leaves the device deselected by loading through the controller strobe with one enable false. Then it offers the processor strobe with each enable in turn made false, combined with every setting of the other strobe and of advance. Long advance runs in both burst orders, started from each of the four start offsets, exercise the wrap and the order arithmetic. A behavioural model compares both outputs after every clock.

// File: rtl/bas_pkg.sv
package bas_pkg;

    // Action chosen for one clock edge, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD_P = 2'd1,
        ACT_LOAD_C = 2'd2,
        ACT_STEP   = 2'd3
    } bas_act_e;

endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb
    import bas_pkg::*;
(
    input  logic     adsp_n,
    input  logic     adsc_n,
    input  logic     adv_n,
    input  logic     ce_n,
    input  logic     ce2,
    input  logic     ce2_n,
    input  logic     sel_q,
    output logic     enabled,
    output bas_act_e act
);

    always_comb begin
        enabled = !ce_n && ce2 && !ce2_n;
        if (!adsp_n && enabled) begin
            act = ACT_LOAD_P;
        end else if (!adsc_n) begin
            act = ACT_LOAD_C;
        end else if (!adv_n && sel_q) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/bas_burst_counter.sv
module bas_burst_counter #(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    output logic [BURST_W-1:0] beat_q
);

    logic [BURST_W-1:0] beat_d;

    always_comb begin
        beat_d = beat_q;
        if (clear) begin
            beat_d = '0;
        end else if (step) begin
            beat_d = beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    // Checks on the counter itself.
    AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (beat_q == '0)); // R5
    AST_BEAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(beat_q)); // R9

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] start_bits,
    input  logic [BURST_W-1:0] beat,
    input  logic               interleave,
    output logic [BURST_W-1:0] low_bits
);

    logic [BURST_W-1:0] xor_bits;
    logic [BURST_W-1:0] sum_bits;

    genvar gi;
    generate
        for (gi = 0; gi < BURST_W; gi++) begin : g_xor
            assign xor_bits[gi] = start_bits[gi] ^ beat[gi];
        end
    endgenerate

    assign sum_bits = start_bits + beat;

    always_comb begin
        low_bits = interleave ? xor_bits : sum_bits;
    end

    // At beat 0 both orders give the start offset.
    always_comb begin
        AST_BEAT0_START: assert (beat != '0 || low_bits == start_bits); // R6
    end

endmodule

// File: rtl/bas_sequencer.sv
module bas_sequencer
    import bas_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              burst_mode,
    output logic [ADDR_W-1:0] array_addr,
    output logic              sel_q
);

    localparam int UPPER_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BURST_W-1:0] start;
        logic               sel;
    } bas_state_t;

    bas_state_t         st_d;
    bas_state_t         st_q;
    bas_act_e           act;
    logic               enabled;
    logic               load;
    logic [BURST_W-1:0] beat_q;
    logic [BURST_W-1:0] low_bits;

    bas_strobe_arb i_arb (
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .ce_n    (ce_n),
        .ce2     (ce2),
        .ce2_n   (ce2_n),
        .sel_q   (st_q.sel),
        .enabled (enabled),
        .act     (act)
    );

    assign load = (act == ACT_LOAD_P) || (act == ACT_LOAD_C);

    bas_burst_counter #(.BURST_W(BURST_W)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .step   (act == ACT_STEP),
        .beat_q (beat_q)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD_P: begin
                st_d.upper = addr_in[ADDR_W-1:BURST_W];
                st_d.start = addr_in[BURST_W-1:0];
                st_d.sel   = 1'b1;
            end
            ACT_LOAD_C: begin
                st_d.upper = addr_in[ADDR_W-1:BURST_W];
                st_d.start = addr_in[BURST_W-1:0];
                st_d.sel   = enabled;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bas_order_map #(.BURST_W(BURST_W)) i_map (
        .start_bits (st_q.start),
        .beat       (beat_q),
        .interleave (burst_mode),
        .low_bits   (low_bits)
    );

    assign array_addr = {st_q.upper, low_bits};
    assign sel_q      = st_q.sel;

    // Port-level checks on the sequencing rules.
    AST_PSTROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n && ce2 && !ce2_n) |=>
            (array_addr == $past(addr_in)) && sel_q); // R2
    AST_CSTROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsc_n && !(!adsp_n && !ce_n && ce2 && !ce2_n)) |=>
            (array_addr == $past(addr_in)) &&
            (sel_q == $past(!ce_n && ce2 && !ce2_n))); // R4
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (adsc_n && (adsp_n || ce_n || !ce2 || ce2_n)) |=>
            $stable(array_addr[ADDR_W-1:BURST_W]) && $stable(sel_q)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && adv_n) |=>
            ($stable(array_addr) || $changed(burst_mode))); // R9
    AST_DESEL_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && adsc_n && (adsp_n || ce_n || !ce2 || ce2_n)) |=>
            ($stable(array_addr) || $changed(burst_mode))); // R10

endmodule

// File: tb/test_bas_sequencer.sv
module test_bas_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] addr_in = '0;
    logic        adsp_n = 1'b1;
    logic        adsc_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        ce_n = 1'b1;
    logic        ce2 = 1'b0;
    logic        ce2_n = 1'b1;
    logic        burst_mode = 1'b1;
    logic [14:0] array_addr;
    logic        sel_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Behavioural reference state.
    int m_upper = 0;
    int m_start = 0;
    int m_beat = 0;
    int m_sel = 0;
    int lfsr = 32'h1d2c;

    always #5 clk = ~clk;

    bas_sequencer i_bas_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_in    (addr_in),
        .adsp_n     (adsp_n),
        .adsc_n     (adsc_n),
        .adv_n      (adv_n),
        .ce_n       (ce_n),
        .ce2        (ce2),
        .ce2_n      (ce2_n),
        .burst_mode (burst_mode),
        .array_addr (array_addr),
        .sel_q      (sel_q)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int exp_addr();
        int low;
        if (burst_mode) low = m_start ^ m_beat;
        else            low = (m_start + m_beat) % 4;
        return m_upper * 4 + low;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (array_addr !== exp_addr() || sel_q !== m_sel[0]) begin
            errors++;
            $display("FAIL %s: actual addr=%h sel=%b expected addr=%h sel=%0d",
                     tag, array_addr, sel_q, exp_addr(), m_sel);
        end
    endtask

    // Drive one cycle's inputs at the falling edge, update model at the
    // rising edge, compare shortly after.
    task automatic cyc(input string tag, input logic [14:0] a, input logic p,
                       input logic c, input logic v, input logic e0,
                       input logic e1, input logic e2);
        int en;
        @(negedge clk);
        addr_in = a; adsp_n = p; adsc_n = c; adv_n = v;
        ce_n = e0; ce2 = e1; ce2_n = e2;
        @(posedge clk);
        en = (!e0 && e1 && !e2) ? 1 : 0;
        if (!p && en == 1) begin
            m_upper = a / 4; m_start = a % 4; m_beat = 0; m_sel = 1;
        end else if (!c) begin
            m_upper = a / 4; m_start = a % 4; m_beat = 0; m_sel = en;
        end else if (!v && m_sel == 1) begin
            m_beat = (m_beat + 1) % 4;
        end
        #2;
        compare(tag);
    endtask

    initial begin
        #12;
        checks++;
        if (array_addr !== '0 || sel_q !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual addr=%h sel=%b expected addr=0 sel=0",
                     array_addr, sel_q);
        end
        rst_n = 1'b1;

        // R2: processor load with enables true, then interleaved bursts (R6)
        burst_mode = 1'b1;
        for (int s = 0; s < 4; s++) begin
            cyc("R2", 15'h5a30 + 15'(s), 0, 1, 1, 0, 1, 0);
            for (int k = 0; k < 5; k++) cyc("R6", 15'h7fff, 1, 1, 0, 0, 1, 0);
        end
        // R7: linear order from each start, including wrap (R8)
        burst_mode = 1'b0;
        for (int s = 0; s < 4; s++) begin
            cyc("R2", 15'h1234 + 15'(s), 0, 0, 0, 0, 1, 0);
            for (int k = 0; k < 4; k++) cyc("R7", 15'h0000, 1, 1, 0, 1, 0, 1);
            cyc("R8", 15'h0003, 1, 1, 1, 0, 1, 0);
        end
        // R9: idle cycles hold
        for (int k = 0; k < 3; k++) cyc("R9", 15'h4444, 1, 1, 1, 0, 1, 0);
        // R5: strobe with advance low restarts at beat 0
        cyc("R5", 15'h0ab2, 1, 0, 0, 0, 1, 0);
        cyc("R5", 15'h0ab2, 1, 1, 0, 0, 1, 0);
        cyc("R5", 15'h3311, 0, 1, 0, 0, 1, 0);
        // R4: controller load with each enable false -> deselected
        cyc("R4", 15'h2001, 1, 0, 1, 1, 1, 0);
        cyc("R4", 15'h2002, 1, 0, 1, 0, 0, 0);
        cyc("R4", 15'h2003, 1, 0, 1, 0, 1, 1);
        // R10: advance ignored while deselected
        for (int k = 0; k < 3; k++) cyc("R10", 15'h0f0f, 1, 1, 0, 0, 1, 0);
        // R3: rejected processor strobe, alone and with controller
        cyc("R3", 15'h6666, 0, 1, 1, 1, 1, 0);
        cyc("R3", 15'h6667, 0, 1, 0, 0, 0, 0);
        cyc("R3", 15'h6668, 0, 0, 1, 0, 1, 1);
        cyc("R4", 15'h7001, 1, 0, 1, 0, 1, 0);
        cyc("R3", 15'h7777, 0, 1, 0, 1, 1, 0);
        cyc("R3", 15'h7778, 0, 1, 1, 0, 0, 0);
        // Mixed pseudo-random traffic in both orders
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr == 0) lfsr = 1;
            burst_mode = lfsr[20];
            cyc("R3", lfsr[14:0], lfsr[15] | lfsr[16], lfsr[17] | lfsr[18],
                lfsr[19], lfsr[22] & lfsr[23], lfsr[24] | lfsr[25],
                lfsr[26] & lfsr[27]);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule